// File: doc/BRIEF.md
# Diskette Controller Host Port File

This block is the set of byte-wide I/O ports through which a host processor drives a two-drive diskette controller. A host access carries a strobe, a direction, a 3-bit port offset and a data byte. Through these ports the host reads a subsystem status byte, a result-type code and a result byte. It also loads a 16-bit pointer to a parameter block held in memory, and it can issue a software reset to the controller.

A write of the pointer's high byte starts an operation. The block raises a one-cycle start pulse toward the command engine and presents the assembled pointer. When the engine finishes, it pulses a done signal together with a result type, an error byte, a ready-changed flag and an interrupt-enable flag. The block stores these values and holds an interrupt flip-flop. That flip-flop drives the interrupt request and status bit 2 until the host reads the result-type port. Command execution and memory access are handled elsewhere.

Port behaviour is fixed by offset. Offset 0 returns the status byte. Offset 1 returns the result type on a read and loads the low pointer byte on a write. A write to offset 2 loads the high pointer byte and starts the operation. Offset 3 returns the result byte. A write to offset 7 performs the software reset. Read data is combinational during a read access and zero at all other times.

Top module: `fdc_host_regs`

## Requirements
- R1: A read of offset 0 returns the status byte. Bit 0 is drive 0 ready, bit 1 is drive 1 ready, bit 2 is the interrupt flip-flop, bit 3 is 1 (controller present) and bits 7..4 are 0.
- R2: A write to offset 1 loads its data into pblk_addr[7:0], visible from the next clock, and does not pulse start.
- R3: A write to offset 2 loads its data into pblk_addr[15:8] and asserts start for exactly the next clock cycle.
- R4: A read of offset 1 returns {6'b0, result type}. From the next clock, irq and status bit 2 are 0.
- R5: On eng_done the result type takes eng_rtype (00 error unlinked, 01 error linked, 10 ready status, 11 reserved). The error byte is captured only when eng_rtype[1] is 0, and the ready-changed flag takes eng_rdy_chg.
- R6: A read of offset 3 returns the stored error byte when the result type is 00. Otherwise it returns the ready byte when the ready-changed flag is set, and 0 when it is clear.
- R7: In the ready byte, bit 6 is drive 0 ready, bit 7 is drive 1 ready, bit 4 is drive 2 ready, bit 5 is drive 3 ready and bits 3..0 are 0. Drives that are absent read 0.
- R8: A write to offset 7 clears the interrupt flip-flop, sets the result type to 10, clears the ready-changed flag and resamples drv_ready into the ready bits. It leaves pblk_addr unchanged.
- R9: eng_done with eng_irq_en sets irq from the next clock. irq then holds until the clearing read of R4 or a software reset. eng_done without eng_irq_en leaves irq unchanged.
- R10: If eng_done with eng_irq_en arrives in the same cycle as a read of offset 1, irq ends up set. If an offset-7 write arrives in the same cycle as eng_done, the reset wins.
- R11: Reads of offsets 2, 4, 5, 6 and 7 return 0. Writes to offsets 0, 3, 4, 5 and 6 change no state. acc_rdata is 0 whenever no read access is presented.
- R12: After hardware reset, irq=0, start=0, pblk_addr=0 and the result type is 10. The ready bits show drv_ready from the second clock after reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Host port access strobe, one cycle per access |
| acc_write | input | 1 | 1 = write access, 0 = read access |
| acc_offset | input | 3 | Port offset from the base address |
| acc_wdata | input | 8 | Host write data |
| acc_rdata | output | 8 | Host read data, valid during a read access |
| drv_ready | input | 2 | Per-drive ready inputs |
| eng_done | input | 1 | Engine completion pulse |
| eng_irq_en | input | 1 | Completion should raise the interrupt |
| eng_rtype | input | 2 | Result type reported by the engine |
| eng_err | input | 8 | Error byte reported by the engine |
| eng_rdy_chg | input | 1 | Drive readiness changed during the operation |
| irq | output | 1 | Interrupt request (interrupt flip-flop) |
| start | output | 1 | One-cycle operation start pulse |
| pblk_addr | output | 16 | Latched parameter block pointer |

## Verification
The assertions take two things for granted. First, every host access is a single-cycle strobe with a stable offset and direction. Second, a software reset and a clearing read never share a cycle, which the single access port makes impossible. They also treat eng_done as a one-cycle pulse that may coincide with any host access. The stimulus applies every access for exactly one clock, with inputs changed only on the falling edge. It drives engine completions as isolated pulses, apart from the priority cases that overlap them with a host access on purpose. The sweep covers every result type, ready-changed value, interrupt-enable value and drive-ready pattern.

// File: rtl/fdc_host_pkg.sv
package fdc_host_pkg;

   typedef enum logic [1:0] {
      RT_ERR_UNLINKED = 2'b00,
      RT_ERR_LINKED   = 2'b01,
      RT_READY        = 2'b10,
      RT_RESERVED     = 2'b11
   } rtype_e;

   // decoded host access, one strobe per port action
   typedef struct packed {
      logic stat_rd;
      logic type_rd;
      logic res_rd;
      logic lo_wr;
      logic hi_wr;
      logic rst_wr;
      logic any_rd;
   } acc_dec_t;

   // bit position of drive d inside the ready byte
   function automatic int rdy_pos(input int d);
      return (d < 2) ? (6 + d) : (2 + d);
   endfunction

   localparam int STAT_PRESENT_BIT = 3;
   localparam int STAT_IRQ_BIT     = 2;
   localparam int STAT_DRV_BITS    = 2;

endpackage

// File: rtl/fdc_port_decode.sv
module fdc_port_decode
   import fdc_host_pkg::*;
#(
   parameter int OFF_W     = 3,
   parameter int OFF_STAT  = 0,
   parameter int OFF_TYPE  = 1,
   parameter int OFF_START = 2,
   parameter int OFF_RES   = 3,
   parameter int OFF_RST   = 7
) (
   input  logic             acc_valid,
   input  logic             acc_write,
   input  logic [OFF_W-1:0] acc_offset,
   output acc_dec_t         dec
);

   localparam logic [OFF_W-1:0] K_STAT  = OFF_W'(OFF_STAT);
   localparam logic [OFF_W-1:0] K_TYPE  = OFF_W'(OFF_TYPE);
   localparam logic [OFF_W-1:0] K_START = OFF_W'(OFF_START);
   localparam logic [OFF_W-1:0] K_RES   = OFF_W'(OFF_RES);
   localparam logic [OFF_W-1:0] K_RST   = OFF_W'(OFF_RST);

   logic rd, wr;

   always_comb begin
      rd          = acc_valid && !acc_write;
      wr          = acc_valid &&  acc_write;
      dec.any_rd  = rd;
      dec.stat_rd = rd && (acc_offset == K_STAT);
      dec.type_rd = rd && (acc_offset == K_TYPE);
      dec.res_rd  = rd && (acc_offset == K_RES);
      dec.lo_wr   = wr && (acc_offset == K_TYPE);
      dec.hi_wr   = wr && (acc_offset == K_START);
      dec.rst_wr  = wr && (acc_offset == K_RST);
   end

endmodule

// File: rtl/fdc_addr_latch.sv
module fdc_addr_latch #(
   parameter int DATA_W = 8,
   localparam int PTR_W = 2 * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lo_wr,
   input  logic              hi_wr,
   input  logic [DATA_W-1:0] wdata,
   output logic [PTR_W-1:0]  addr,
   output logic              start
);

   logic [DATA_W-1:0] lo_q, hi_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q  <= '0;
         hi_q  <= '0;
         start <= 1'b0;
      end else begin
         if (lo_wr) lo_q <= wdata;
         if (hi_wr) hi_q <= wdata;
         start <= hi_wr;
      end
   end

   assign addr = {hi_q, lo_q};

endmodule

// File: rtl/fdc_result_store.sv
module fdc_result_store
   import fdc_host_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int NUM_DRV = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               soft_rst,
   input  logic               type_rd,
   input  logic [NUM_DRV-1:0] drv_ready,
   input  logic               eng_done,
   input  logic               eng_irq_en,
   input  logic [1:0]         eng_rtype,
   input  logic [DATA_W-1:0]  eng_err,
   input  logic               eng_rdy_chg,
   output rtype_e             rtype,
   output logic [DATA_W-1:0]  err_byte,
   output logic               rdy_chg,
   output logic [NUM_DRV-1:0] rdy_snap,
   output logic               irq_ff
);

   logic snap_pend;
   logic take_err;

   assign take_err = eng_done && !eng_rtype[1];

   // result type, error byte and ready-changed flag
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rtype    <= RT_READY;
         err_byte <= '0;
         rdy_chg  <= 1'b0;
      end else if (soft_rst) begin
         rtype    <= RT_READY;
         rdy_chg  <= 1'b0;
      end else if (eng_done) begin
         rtype    <= rtype_e'(eng_rtype);
         rdy_chg  <= eng_rdy_chg;
         if (take_err) err_byte <= eng_err;
      end
   end

   // drive-ready snapshot, taken after hardware reset and on soft reset
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdy_snap  <= '0;
         snap_pend <= 1'b1;
      end else begin
         snap_pend <= 1'b0;
         if (snap_pend || soft_rst) rdy_snap <= drv_ready;
      end
   end

   // interrupt flip-flop: reset > completion set > clearing read
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      irq_ff <= 1'b0;
      else if (soft_rst)               irq_ff <= 1'b0;
      else if (eng_done && eng_irq_en) irq_ff <= 1'b1;
      else if (type_rd)                irq_ff <= 1'b0;
   end

endmodule

// File: rtl/fdc_read_mux.sv
module fdc_read_mux
   import fdc_host_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int NUM_DRV = 2
) (
   input  acc_dec_t           dec,
   input  rtype_e             rtype,
   input  logic [DATA_W-1:0]  err_byte,
   input  logic               rdy_chg,
   input  logic [NUM_DRV-1:0] rdy_snap,
   input  logic               irq_ff,
   output logic [DATA_W-1:0]  rdata
);

   localparam int STAT_DRV = (NUM_DRV < STAT_DRV_BITS) ? NUM_DRV : STAT_DRV_BITS;

   logic [DATA_W-1:0] stat_b, ready_b, res_b, type_b;

   always_comb begin
      stat_b = '0;
      stat_b[STAT_PRESENT_BIT] = 1'b1;
      stat_b[STAT_IRQ_BIT]     = irq_ff;
      for (int d = 0; d < STAT_DRV; d++) stat_b[d] = rdy_snap[d];
   end

   always_comb begin
      ready_b = '0;
      for (int d = 0; d < NUM_DRV; d++) ready_b[rdy_pos(d)] = rdy_snap[d];
   end

   always_comb begin
      type_b = {{(DATA_W-2){1'b0}}, rtype};
      if (rtype == RT_ERR_UNLINKED) res_b = err_byte;
      else if (rdy_chg)             res_b = ready_b;
      else                          res_b = '0;
   end

   always_comb begin
      rdata = '0;
      if (dec.stat_rd)      rdata = stat_b;
      else if (dec.type_rd) rdata = type_b;
      else if (dec.res_rd)  rdata = res_b;
   end

endmodule

// File: rtl/fdc_host_regs.sv
module fdc_host_regs
   import fdc_host_pkg::*;
#(
   parameter int OFF_W     = 3,
   parameter int DATA_W    = 8,
   parameter int NUM_DRV   = 2,
   parameter int OFF_STAT  = 0,
   parameter int OFF_TYPE  = 1,
   parameter int OFF_START = 2,
   parameter int OFF_RES   = 3,
   parameter int OFF_RST   = 7
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  acc_valid,
   input  logic                  acc_write,
   input  logic [OFF_W-1:0]      acc_offset,
   input  logic [DATA_W-1:0]     acc_wdata,
   output logic [DATA_W-1:0]     acc_rdata,
   input  logic [NUM_DRV-1:0]    drv_ready,
   input  logic                  eng_done,
   input  logic                  eng_irq_en,
   input  logic [1:0]            eng_rtype,
   input  logic [DATA_W-1:0]     eng_err,
   input  logic                  eng_rdy_chg,
   output logic                  irq,
   output logic                  start,
   output logic [2*DATA_W-1:0]   pblk_addr
);

   localparam int N_PORTS = 1 << OFF_W;

   generate
      if (DATA_W != 8) begin : g_bad_width
         $error("fdc_host_regs: byte layouts need DATA_W of 8");
      end
      if (NUM_DRV < 1 || NUM_DRV > 4) begin : g_bad_drv
         $error("fdc_host_regs: NUM_DRV must be 1 to 4");
      end
      if (OFF_RST >= N_PORTS || OFF_RES >= N_PORTS || OFF_START >= N_PORTS) begin : g_bad_off
         $error("fdc_host_regs: port offset outside OFF_W range");
      end
   endgenerate

   acc_dec_t          dec;
   rtype_e            rtype;
   logic [DATA_W-1:0] err_byte;
   logic              rdy_chg;
   logic [NUM_DRV-1:0] rdy_snap;
   logic              irq_ff;

   fdc_port_decode #(
      .OFF_W(OFF_W), .OFF_STAT(OFF_STAT), .OFF_TYPE(OFF_TYPE),
      .OFF_START(OFF_START), .OFF_RES(OFF_RES), .OFF_RST(OFF_RST)
   ) u_dec (
      .acc_valid (acc_valid),
      .acc_write (acc_write),
      .acc_offset(acc_offset),
      .dec       (dec)
   );

   fdc_addr_latch #(.DATA_W(DATA_W)) u_addr (
      .clk  (clk),
      .rst_n(rst_n),
      .lo_wr(dec.lo_wr),
      .hi_wr(dec.hi_wr),
      .wdata(acc_wdata),
      .addr (pblk_addr),
      .start(start)
   );

   fdc_result_store #(.DATA_W(DATA_W), .NUM_DRV(NUM_DRV)) u_res (
      .clk        (clk),
      .rst_n      (rst_n),
      .soft_rst   (dec.rst_wr),
      .type_rd    (dec.type_rd),
      .drv_ready  (drv_ready),
      .eng_done   (eng_done),
      .eng_irq_en (eng_irq_en),
      .eng_rtype  (eng_rtype),
      .eng_err    (eng_err),
      .eng_rdy_chg(eng_rdy_chg),
      .rtype      (rtype),
      .err_byte   (err_byte),
      .rdy_chg    (rdy_chg),
      .rdy_snap   (rdy_snap),
      .irq_ff     (irq_ff)
   );

   fdc_read_mux #(.DATA_W(DATA_W), .NUM_DRV(NUM_DRV)) u_mux (
      .dec     (dec),
      .rtype   (rtype),
      .err_byte(err_byte),
      .rdy_chg (rdy_chg),
      .rdy_snap(rdy_snap),
      .irq_ff  (irq_ff),
      .rdata   (acc_rdata)
   );

   assign irq = irq_ff;

endmodule

// File: rtl/fdc_host_regs_chk.sv
module fdc_host_regs_chk #(
   parameter int OFF_W     = 3,
   parameter int DATA_W    = 8,
   parameter int NUM_DRV   = 2,
   parameter int OFF_STAT  = 0,
   parameter int OFF_TYPE  = 1,
   parameter int OFF_START = 2,
   parameter int OFF_RST   = 7
) (
   input logic                clk,
   input logic                rst_n,
   input logic                acc_valid,
   input logic                acc_write,
   input logic [OFF_W-1:0]    acc_offset,
   input logic [DATA_W-1:0]   acc_wdata,
   input logic [DATA_W-1:0]   acc_rdata,
   input logic [NUM_DRV-1:0]  drv_ready,
   input logic                eng_done,
   input logic                eng_irq_en,
   input logic [1:0]          eng_rtype,
   input logic [DATA_W-1:0]   eng_err,
   input logic                eng_rdy_chg,
   input logic                irq,
   input logic                start,
   input logic [2*DATA_W-1:0] pblk_addr
);

   logic rd_stat, rd_type, wr_lo, wr_hi, wr_rst, any_rd;

   assign any_rd  = acc_valid && !acc_write;
   assign rd_stat = any_rd && (acc_offset == OFF_W'(OFF_STAT));
   assign rd_type = any_rd && (acc_offset == OFF_W'(OFF_TYPE));
   assign wr_lo   = acc_valid && acc_write && (acc_offset == OFF_W'(OFF_TYPE));
   assign wr_hi   = acc_valid && acc_write && (acc_offset == OFF_W'(OFF_START));
   assign wr_rst  = acc_valid && acc_write && (acc_offset == OFF_W'(OFF_RST));

   p_stat_layout_r1: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stat |-> (acc_rdata[DATA_W-1:3] == 1 && acc_rdata[2] == irq));

   p_lo_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_lo |=> (pblk_addr[DATA_W-1:0] == $past(acc_wdata)));

   p_hi_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hi |=> (start && pblk_addr[2*DATA_W-1:DATA_W] == $past(acc_wdata)));

   p_start_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> $past(wr_hi));

   p_type_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_type |-> (acc_rdata[DATA_W-1:2] == '0));

   p_clear_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_type && !eng_done) |=> !irq);

   p_soft_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_rst |=> !irq);

   p_irq_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_done && eng_irq_en && !wr_rst) |=> irq);

   p_irq_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !rd_type && !wr_rst) |=> irq);

   p_idle_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !any_rd |-> (acc_rdata == '0));

endmodule

bind fdc_host_regs fdc_host_regs_chk #(
   .OFF_W(OFF_W), .DATA_W(DATA_W), .NUM_DRV(NUM_DRV),
   .OFF_STAT(OFF_STAT), .OFF_TYPE(OFF_TYPE), .OFF_START(OFF_START), .OFF_RST(OFF_RST)
) u_chk (
   .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
   .acc_offset(acc_offset), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
   .drv_ready(drv_ready), .eng_done(eng_done), .eng_irq_en(eng_irq_en),
   .eng_rtype(eng_rtype), .eng_err(eng_err), .eng_rdy_chg(eng_rdy_chg),
   .irq(irq), .start(start), .pblk_addr(pblk_addr)
);

// File: tb/sim_fdc_host_regs.sv
`timescale 1ns/1ps
module sim_fdc_host_regs;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       acc_valid = 1'b0, acc_write = 1'b0;
   logic [2:0] acc_offset = '0;
   logic [7:0] acc_wdata = '0;
   logic [7:0] acc_rdata;
   logic [1:0] drv_ready = 2'b01;
   logic       eng_done = 1'b0, eng_irq_en = 1'b0, eng_rdy_chg = 1'b0;
   logic [1:0] eng_rtype = '0;
   logic [7:0] eng_err = '0;
   logic       irq, start;
   logic [15:0] pblk_addr;

   int total = 0;
   int bad   = 0;
   logic [7:0] cap;

   // reference model state
   logic [1:0]  m_rtype;
   logic [7:0]  m_err;
   logic        m_chg, m_irq;
   logic [1:0]  m_rdy;
   logic [15:0] m_addr;

   always #5 clk = ~clk;

   fdc_host_regs u0 (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
      .acc_offset(acc_offset), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
      .drv_ready(drv_ready), .eng_done(eng_done), .eng_irq_en(eng_irq_en),
      .eng_rtype(eng_rtype), .eng_err(eng_err), .eng_rdy_chg(eng_rdy_chg),
      .irq(irq), .start(start), .pblk_addr(pblk_addr)
   );

   task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%h exp=%h at %0t", req, got, exp, $time);
      end
   endtask

   function automatic logic [7:0] exp_stat();
      return {4'b0000, 1'b1, m_irq, m_rdy[1], m_rdy[0]};
   endfunction

   function automatic logic [7:0] exp_res();
      if (m_rtype == 2'b00) return m_err;
      if (m_chg) return {m_rdy[1], m_rdy[0], 6'b0};
      return 8'h00;
   endfunction

   function automatic logic [7:0] exp_read(input int o);
      case (o)
         0:       return exp_stat();
         1:       return {6'b0, m_rtype};
         3:       return exp_res();
         default: return 8'h00;
      endcase
   endfunction

   // one clock: host access and/or engine completion, read data captured before the edge
   task automatic step(input logic v, input logic w, input int o, input logic [7:0] d,
                       input logic dn, input logic ie, input logic [1:0] rt,
                       input logic [7:0] e, input logic ch);
      acc_valid = v; acc_write = w; acc_offset = 3'(o); acc_wdata = d;
      eng_done = dn; eng_irq_en = ie; eng_rtype = rt; eng_err = e; eng_rdy_chg = ch;
      #1 cap = acc_rdata;
      @(negedge clk);
      acc_valid = 1'b0; acc_write = 1'b0; eng_done = 1'b0; eng_irq_en = 1'b0;
   endtask

   task automatic rd(input int o);
      step(1'b1, 1'b0, o, 8'h00, 1'b0, 1'b0, 2'b00, 8'h00, 1'b0);
      if (o == 1) m_irq = 1'b0;
   endtask

   task automatic wr(input int o, input logic [7:0] d);
      step(1'b1, 1'b1, o, d, 1'b0, 1'b0, 2'b00, 8'h00, 1'b0);
      if (o == 1) m_addr[7:0] = d;
      if (o == 2) m_addr[15:8] = d;
      if (o == 7) begin m_irq = 1'b0; m_rtype = 2'b10; m_chg = 1'b0; m_rdy = drv_ready; end
   endtask

   task automatic eng(input logic [1:0] rt, input logic [7:0] e, input logic ch, input logic ie);
      step(1'b0, 1'b0, 0, 8'h00, 1'b1, ie, rt, e, ch);
      m_rtype = rt; m_chg = ch;
      if (!rt[1]) m_err = e;
      if (ie) m_irq = 1'b1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      m_rtype = 2'b10; m_err = 8'h00; m_chg = 1'b0; m_irq = 1'b0;
      m_rdy = 2'b01; m_addr = 16'h0000;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R12 reset state, R11 idle read data
      chk("R12 irq", {15'b0, irq}, 16'h0);
      chk("R12 start", {15'b0, start}, 16'h0);
      chk("R12 addr", pblk_addr, 16'h0000);
      chk("R11 idle rdata", {8'h0, acc_rdata}, 16'h0);
      for (int o = 0; o < 8; o++) begin
         rd(o);
         chk($sformatf("R1/R11/R12 read off%0d", o), {8'h0, cap}, {8'h0, exp_read(o)});
      end

      // R2 / R3 pointer load and start pulse
      wr(1, 8'h34);
      chk("R2 low byte", pblk_addr, 16'h0034);
      chk("R2 no start", {15'b0, start}, 16'h0);
      wr(2, 8'h12);
      chk("R3 start pulse", {15'b0, start}, 16'h1);
      chk("R3 address", pblk_addr, 16'h1234);
      @(negedge clk);
      chk("R3 start one cycle", {15'b0, start}, 16'h0);

      // R4 R5 R6 R7 R9 sweep over result type, changed flag, interrupt enable
      for (int rt = 0; rt < 4; rt++)
         for (int ch = 0; ch < 2; ch++)
            for (int ie = 0; ie < 2; ie++) begin
               eng(2'(rt), 8'(8'h81 ^ (rt << 3) ^ (ch << 1) ^ (ie << 5)), 1'(ch), 1'(ie));
               chk("R9 irq after done", {15'b0, irq}, {15'b0, m_irq});
               rd(0);
               chk("R1 status", {8'h0, cap}, {8'h0, exp_stat()});
               rd(3);
               chk("R6 R7 result byte", {8'h0, cap}, {8'h0, exp_res()});
               rd(1);
               chk("R4 R5 result type", {8'h0, cap}, {8'h0, 6'b0, m_rtype});
               chk("R4 irq cleared", {15'b0, irq}, 16'h0);
            end

      // R8 soft reset resamples each drive-ready pattern; R7 ready byte
      for (int r = 0; r < 4; r++) begin
         eng(2'b00, 8'h5A, 1'b1, 1'b1);
         drv_ready = 2'(r);
         wr(7, 8'h00);
         chk("R8 irq cleared", {15'b0, irq}, 16'h0);
         chk("R8 address kept", pblk_addr, m_addr);
         rd(1);
         chk("R8 result type 10", {8'h0, cap}, 16'h0002);
         rd(0);
         chk("R8 ready bits", {8'h0, cap}, {8'h0, exp_stat()});
         rd(3);
         chk("R8 changed flag cleared", {8'h0, cap}, 16'h0000);
         eng(2'b10, 8'h00, 1'b1, 1'b0);
         rd(3);
         chk("R7 ready byte", {8'h0, cap}, {8'h0, m_rdy[1], m_rdy[0], 6'b0});
      end

      // R9 hold, done without enable leaves irq
      eng(2'b10, 8'h00, 1'b0, 1'b1);
      repeat (5) @(negedge clk);
      chk("R9 irq holds", {15'b0, irq}, 16'h1);
      eng(2'b01, 8'hC3, 1'b0, 1'b0);
      chk("R9 irq unchanged by done", {15'b0, irq}, 16'h1);
      rd(1);
      chk("R9 cleared by read", {15'b0, irq}, 16'h0);

      // R10 same-cycle priorities
      step(1'b1, 1'b0, 1, 8'h00, 1'b1, 1'b1, 2'b01, 8'h77, 1'b0);
      m_rtype = 2'b01; m_err = 8'h77; m_chg = 1'b0; m_irq = 1'b1;
      chk("R10 set beats clearing read", {15'b0, irq}, 16'h1);
      step(1'b1, 1'b1, 7, 8'h00, 1'b1, 1'b1, 2'b00, 8'h66, 1'b1);
      m_irq = 1'b0; m_rtype = 2'b10; m_chg = 1'b0; m_rdy = drv_ready;
      chk("R10 soft reset beats done", {15'b0, irq}, 16'h0);
      rd(1);
      chk("R10 type after reset", {8'h0, cap}, 16'h0002);

      // R11 writes to offsets without a write function change nothing
      eng(2'b00, 8'h3C, 1'b0, 1'b1);
      foreach (cap[i]) if (i == 0) begin end
      for (int o = 0; o < 7; o++) begin
         if (o == 1 || o == 2) continue;
         wr(o, 8'hFF);
         chk("R11 no start", {15'b0, start}, 16'h0);
      end
      chk("R11 address kept", pblk_addr, m_addr);
      chk("R11 irq kept", {15'b0, irq}, 16'h1);
      for (int o = 7; o >= 0; o--) begin
         rd(o);
         chk($sformatf("R11 read back off%0d", o), {8'h0, cap}, {8'h0, exp_read(o)});
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule